// File: doc/BRIEF.md
# I2C Clock Period Generator

This block produces the clock line of an I2C master from two programmable counts: one sets how long the master holds SCL low, the other sets how long the line stays high. Each count is 9 bits wide. A count unit lasts one or two input clock cycles, chosen by a select input. The output is an open-drain pull-down request. When it is 0 the line is released and the external pull-up takes it high.

The low phase begins on the clock edge where the pull-down is applied. The high phase behaves differently. The line is released, but counting waits until the registered copy of the SCL input reads high. A slave that stretches the clock therefore extends the high phase, and so does a slow rise time. If SCL falls again while the high phase is counting, the count restarts from zero. A one-cycle tick marks the first cycle of every counted phase.

A parameter selects a narrow variant without the ninth count bit. In that variant any count above 255 is clamped to 255.

Top module: `sclPeriodGen`

## Requirements
- R1: While `rstN` is low, and from the first cycle after `enable` is sampled low, `sclPullLow` and `phaseTick` are 0 and both counters are cleared.
- R2: The low phase (`sclPullLow` = 1) lasts max(lowCount,1)·D cycles, where D is the unit length. The first low phase starts in the cycle after `enable` is first sampled high.
- R3: When SCL follows the drive, the released phase lasts 1 + max(highCount,1)·D cycles. The extra cycle is the registered sampling of `sclSense`.
- R4: `halfRate` = 0 gives D = 1. `halfRate` = 1 gives D = 2.
- R5: All 9 count bits are used, so values from 256 to 511 give phases longer than 255 units.
- R6: A count of 0 acts as a count of 1.
- R7: While the sampled SCL input is low during the released phase, the high count stays at zero and no tick is issued. Counting starts once SCL is seen high, and max(highCount,1)·D released cycles then follow the cycle in which SCL rose.
- R8: If SCL falls while the high phase is counting, the count restarts. After SCL rises again, the full max(highCount,1)·D released cycles follow.
- R9: `phaseTick` is high for exactly the first cycle of each low and high phase that follows a counted phase. It is never high on the enable-driven start or on a disable.
- R10: With `WIDE_COUNTS` = 0, counts above 255 are clamped to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the clock generator; low releases SCL and clears the counters |
| lowCount | input | CNT_W | Low phase length in units |
| highCount | input | CNT_W | High phase length in units |
| halfRate | input | 1 | Unit length select: 0 = 1 cycle, 1 = 2 cycles |
| sclSense | input | 1 | SCL line level as seen at the pad |
| sclPullLow | output | 1 | 1 = pull SCL low, 0 = release |
| phaseTick | output | 1 | One-cycle pulse at each counted phase boundary |

## Verification
The hardest case to reach is SCL falling again partway through a high phase that is already counting. The bench models the wired line as the release of the drive ANDed with an external stretch signal. It waits for the high-phase tick and lets three units count. It then pulls the line low for two cycles and checks that the full high length follows the second rise. Holding the stretch for forty cycles covers the held-low case. A second, narrow instance driven from the same inputs exercises the clamp.

// File: rtl/sclGenPkg.sv
package sclGenPkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_REL  = 2'd2
  } sclState_e;

  // strobes from control into the datapath
  typedef struct packed {
    logic clear;    // zero prescaler and unit counter
    logic run;      // advance prescaler / unit counter
    logic selHigh;  // compare against the high count
  } dpStrobe_t;
endpackage

// File: rtl/sclGenDatapath.sv
module sclGenDatapath
  import sclGenPkg::*;
#(
  parameter int CNT_W       = 9,
  parameter bit WIDE_COUNTS = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfRate,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] highCount,
  input  dpStrobe_t        strobe,
  output logic             phaseDone
);
  localparam int NARROW_MAX = (1 << (CNT_W - 1)) - 1;
  localparam int NUM_PHASES = 2;

  logic [CNT_W-1:0] rawCount [NUM_PHASES];
  logic [CNT_W-1:0] effCount [NUM_PHASES];
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] unitCnt;
  logic             preCnt;
  logic             unitTick;

  assign rawCount[0] = lowCount;
  assign rawCount[1] = highCount;

  // per-phase limit: optional clamp (R10), then zero mapped to one (R6)
  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    logic [CNT_W-1:0] limited;
    if (WIDE_COUNTS) begin : g_wide
      assign limited = rawCount[p];
    end else begin : g_narrow
      assign limited = (rawCount[p] > CNT_W'(NARROW_MAX)) ? CNT_W'(NARROW_MAX)
                                                          : rawCount[p];
    end
    assign effCount[p] = (limited == '0) ? CNT_W'(1) : limited;
  end

  assign target    = strobe.selHigh ? effCount[1] : effCount[0];
  assign unitTick  = !halfRate || preCnt;               // R4
  assign phaseDone = strobe.run && unitTick && (unitCnt == target - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= 1'b0;
      unitCnt <= '0;
    end else if (strobe.clear || phaseDone) begin
      preCnt  <= 1'b0;
      unitCnt <= '0;
    end else if (strobe.run) begin
      if (unitTick) begin
        preCnt  <= 1'b0;
        unitCnt <= unitCnt + CNT_W'(1);
      end else begin
        preCnt  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sclGenCtrl.sv
module sclGenCtrl
  import sclGenPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      sclSense,
  input  logic      phaseDone,
  output dpStrobe_t strobe,
  output logic      sclPullLow,
  output logic      phaseTick,
  output sclState_e state,
  output logic      senseSeen
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phaseTick <= 1'b0;
      senseSeen <= 1'b0;
    end else begin
      senseSeen <= sclSense;
      phaseTick <= 1'b0;
      if (!enable) begin
        state <= ST_IDLE;                        // R1
      end else begin
        case (state)
          ST_IDLE: state <= ST_LOW;              // R2 first phase, no tick
          ST_LOW: if (phaseDone) begin
            state     <= ST_REL;
            phaseTick <= 1'b1;                   // R9
          end
          ST_REL: if (phaseDone) begin
            state     <= ST_LOW;
            phaseTick <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobe = '{clear: 1'b1, run: 1'b0, selHigh: 1'b0};
    case (state)
      ST_LOW: strobe = '{clear: 1'b0, run: 1'b1, selHigh: 1'b0};
      // R7/R8: high count runs only while the line is seen high
      ST_REL: strobe = '{clear: !senseSeen, run: senseSeen, selHigh: 1'b1};
      default: ;
    endcase
  end

  assign sclPullLow = (state == ST_LOW);
endmodule

// File: rtl/sclPeriodGen.sv
module sclPeriodGen
  import sclGenPkg::*;
#(
  parameter int CNT_W       = 9,
  parameter bit WIDE_COUNTS = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] highCount,
  input  logic             halfRate,
  input  logic             sclSense,
  output logic             sclPullLow,
  output logic             phaseTick
);
  dpStrobe_t strobe;
  logic      phaseDone;
  sclState_e ctrlState;
  logic      senseSeen;

  sclGenCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .sclSense  (sclSense),
    .phaseDone (phaseDone),
    .strobe    (strobe),
    .sclPullLow(sclPullLow),
    .phaseTick (phaseTick),
    .state     (ctrlState),
    .senseSeen (senseSeen)
  );

  sclGenDatapath #(.CNT_W(CNT_W), .WIDE_COUNTS(WIDE_COUNTS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .halfRate (halfRate),
    .lowCount (lowCount),
    .highCount(highCount),
    .strobe   (strobe),
    .phaseDone(phaseDone)
  );
endmodule

// File: rtl/sclPeriodGenChk.sv
module sclPeriodGenChk
  import sclGenPkg::*;
#(
  parameter int CNT_W = 9
) (
  input logic      clk,
  input logic      rstN,
  input logic      enable,
  input logic      sclPullLow,
  input logic      phaseTick,
  input sclState_e ctrlState,
  input logic      senseSeen
);
  localparam int LOW_MAX = 2 * ((1 << CNT_W) - 1);

  int unsigned lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           lowRun <= 0;
    else if (sclPullLow) lowRun <= lowRun + 1;
    else                 lowRun <= 0;
  end

  // R1
  disable_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclPullLow && !phaseTick));

  // R9
  tick_on_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseTick |-> (sclPullLow != $past(sclPullLow)));

  // R9
  release_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sclPullLow) && $past(enable)) |-> phaseTick);

  // R7
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_REL && !senseSeen) |=> (!sclPullLow && !phaseTick));

  // R2
  low_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowRun <= LOW_MAX);
endmodule

bind sclPeriodGen sclPeriodGenChk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .sclPullLow(sclPullLow),
  .phaseTick (phaseTick),
  .ctrlState (ctrlState),
  .senseSeen (senseSeen)
);

// File: tb/tb_sclPeriodGen.sv
module tb_sclPeriodGen;
  localparam int CNT_W = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [CNT_W-1:0] lowCount = '0;
  logic [CNT_W-1:0] highCount = '0;
  logic halfRate = 1'b0;
  logic stretch = 1'b0;
  logic sclPullLow, phaseTick, pullN, tickN;
  logic sclSense, senseN;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign sclSense = !sclPullLow && !stretch;  // wired line with external stretch
  assign senseN   = !pullN;

  sclPeriodGen #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .lowCount(lowCount),
    .highCount(highCount), .halfRate(halfRate), .sclSense(sclSense),
    .sclPullLow(sclPullLow), .phaseTick(phaseTick));

  sclPeriodGen #(.CNT_W(CNT_W), .WIDE_COUNTS(1'b0)) dutNarrow (
    .clk(clk), .rstN(rstN), .enable(enable), .lowCount(lowCount),
    .highCount(highCount), .halfRate(halfRate), .sclSense(senseN),
    .sclPullLow(pullN), .phaseTick(tickN));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(int lo, int hi, bit half);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    lowCount = CNT_W'(lo);
    highCount = CNT_W'(hi);
    halfRate = half;
    enable = 1'b1;
  endtask

  // sync on a ticked low start, then measure one low and one high phase
  task automatic measure(bit narrow, output int loLen, output int hiLen);
    int guard = 0;
    loLen = 0;
    hiLen = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!((narrow ? pullN : sclPullLow) && (narrow ? tickN : phaseTick)) && guard < 5000);
    loLen = 1;
    forever begin
      @(negedge clk);
      if (narrow ? pullN : sclPullLow) loLen++;
      else break;
    end
    check("R9 high-start tick", int'(narrow ? tickN : phaseTick), 1);
    hiLen = 1;
    forever begin
      @(negedge clk);
      if (!(narrow ? pullN : sclPullLow)) hiLen++;
      else break;
    end
    check("R9 low-start tick", int'(narrow ? tickN : phaseTick), 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 reset pull", int'(sclPullLow), 0);
    check("R1 reset tick", int'(phaseTick), 0);
  endtask

  task automatic testFirstPhase();
    int len = 0;
    restart(5, 3, 1'b0);
    @(negedge clk);
    check("R2 first low starts", int'(sclPullLow), 1);
    check("R9 no tick on enable", int'(phaseTick), 0);
    len = 1;
    forever begin
      @(negedge clk);
      if (sclPullLow) len++;
      else break;
    end
    check("R2 first low length", len, 5);
  endtask

  task automatic testBasic();
    int lo, hi;
    restart(5, 3, 1'b0);
    measure(1'b0, lo, hi);
    check("R2 low D=1", lo, 5);
    check("R3 high D=1", hi, 4);
    restart(5, 3, 1'b1);
    measure(1'b0, lo, hi);
    check("R4 low D=2", lo, 10);
    check("R4 high D=2", hi, 7);
  endtask

  task automatic testWide();
    int lo, hi;
    restart(300, 260, 1'b0);
    measure(1'b0, lo, hi);
    check("R5 low 300", lo, 300);
    check("R5 high 260", hi, 261);
    restart(300, 260, 1'b0);
    measure(1'b1, lo, hi);
    check("R10 narrow low clamp", lo, 255);
    check("R10 narrow high clamp", hi, 256);
  endtask

  task automatic testZero();
    int lo, hi;
    restart(0, 0, 1'b0);
    measure(1'b0, lo, hi);
    check("R6 zero low", lo, 1);
    check("R6 zero high", hi, 2);
  endtask

  task automatic testStretch();
    int bad = 0;
    int rel = 0;
    int guard = 0;
    restart(3, 4, 1'b0);
    do begin @(negedge clk); guard++; end while (!(sclPullLow && phaseTick) && guard < 1000);
    stretch = 1'b1;
    do @(negedge clk); while (sclPullLow);
    repeat (40) begin
      @(negedge clk);
      if (sclPullLow || phaseTick) bad++;
    end
    check("R7 held while stretched", bad, 0);
    stretch = 1'b0;
    forever begin
      @(negedge clk);
      if (!sclPullLow) rel++;
      else break;
    end
    check("R7 high after stretch", rel, 4);
    check("R9 tick after stretch", int'(phaseTick), 1);
  endtask

  task automatic testMidDrop();
    int rel = 0;
    int guard = 0;
    restart(3, 6, 1'b0);
    do begin @(negedge clk); guard++; end while (!(!sclPullLow && phaseTick) && guard < 1000);
    repeat (3) @(negedge clk);
    stretch = 1'b1;
    repeat (2) @(negedge clk);
    stretch = 1'b0;
    forever begin
      @(negedge clk);
      if (!sclPullLow) rel++;
      else break;
    end
    check("R8 restart after mid-high drop", rel, 6);
  endtask

  task automatic testDisable();
    int bad = 0;
    int guard = 0;
    restart(20, 20, 1'b0);
    do begin @(negedge clk); guard++; end while (!(sclPullLow && phaseTick) && guard < 1000);
    repeat (4) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R1 release after disable", int'(sclPullLow), 0);
    repeat (10) begin
      @(negedge clk);
      if (sclPullLow || phaseTick) bad++;
    end
    check("R1 idle while disabled", bad, 0);
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testFirstPhase();
    testBasic();
    testWide();
    testZero();
    testStretch();
    testMidDrop();
    testDisable();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule